// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker converts a 32-bit I/O virtual address into a physical address. It reads descriptors from a two-level table held in memory, using a plain read port that has at most one read in flight. The first level is indexed by the top twelve address bits and holds one word per 1 MiB region. That word either maps the whole region directly or points to a second-level table. The second-level table has 256 words, one per 4 KiB slot. Each of its words maps a 4 KiB page, or it is one of sixteen identical copies that together map a 64 KiB page.

A client presents an address with a valid/ready handshake while the enable input is high. The walker then issues one or two reads and returns a single-cycle response. The response carries either the composed physical address or a fault flag together with the virtual address that failed. The table base is a plain input and is sampled when a request is accepted.

Top module: `iova_walker`

## Requirements
- R1: After reset, and after a reset applied in the middle of a walk, rsp_valid and mem_req_valid are low and the walker is idle; req_ready is high only when en is high.
- R2: While en is low, req_ready stays low, and a pending request causes no memory read and no response.
- R3: The first read goes to tbl_base + 4 * iova[31:20]. This holds for indices 0 and 4095 and for any base value.
- R4: A first-level word with bits[1:0] = 2'b10 ends the walk after one read with pa = {word[31:20], iova[19:0]}.
- R5: A first-level word with bits[1:0] = 2'b00 or 2'b11 ends the walk after one read with rsp_fault = 1, rsp_fault_addr = iova and rsp_pa = 0.
- R6: A first-level word with bits[1:0] = 2'b01 causes a second read at {word[31:10], iova[19:12], 2'b00}.
- R7: A second-level word with bit 1 set gives pa = {word[31:12], iova[11:0]}. This applies whatever bit 0 holds.
- R8: A second-level word with bits[1:0] = 2'b01 gives pa = {word[31:16], iova[15:0]}, for any of the 16 slots of the 64 KiB page.
- R9: A second-level word with bits[1:0] = 2'b00 gives rsp_fault = 1, rsp_fault_addr = iova and rsp_pa = 0, after two reads.
- R10: Only one request is in progress at a time. req_ready is low from acceptance until the response. A second read is never requested while a read is outstanding. A read request holds its address until it is accepted.
- R11: rsp_valid is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Allows new requests to be accepted |
| tbl_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_iova | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Read request to table memory |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word read |
| rsp_valid | output | 1 | One-cycle translation result strobe |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_fault_addr | output | 32 | Virtual address that faulted (zero otherwise) |

## Verification
On every cycle, the embedded properties check the handshake rules. The read address is held while the memory stalls, the input handshake drops after acceptance, the result strobe lasts one cycle, and the walker stays quiet while disabled and idle. They also check that a fault result never carries a physical address. The bench scenarios are the only evidence for the descriptor decoding and the address composition. That covers every descriptor encoding, the index arithmetic at both ends of the first-level table, the second-level address formed from the pointer word, the 64 KiB page replicas, the number of reads per walk, and recovery from a reset in the middle of a walk.

// File: rtl/walk_pkg.sv
// Shared geometry and types of the translation walker.
// Assumes 32-bit words, byte addressing and 4-byte descriptors.
package walk_pkg;
    localparam int VA_W     = 32;   // virtual and physical address width
    localparam int SECT_SH  = 20;   // 1 MiB region offset bits
    localparam int LPG_SH   = 16;   // 64 KiB page offset bits
    localparam int SPG_SH   = 12;   // 4 KiB page offset bits
    localparam int WORD_SH  = 2;    // byte offset of a 4-byte descriptor
    localparam int L1_BITS  = VA_W - SECT_SH;            // first-level index width
    localparam int L2_BITS  = SECT_SH - SPG_SH;          // second-level index width
    localparam int PTR_SH   = L2_BITS + WORD_SH;         // low bits dropped from a table pointer

    typedef enum logic [1:0] {
        DK_FAULT = 2'd0,
        DK_NEXT  = 2'd1,
        DK_LEAF  = 2'd2
    } desc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_WT1  = 3'd2,
        ST_RD2  = 3'd3,
        ST_WT2  = 3'd4,
        ST_DONE = 3'd5
    } walk_state_e;
endpackage

// File: rtl/walk_l1_index.sv
// First-level descriptor address: table base plus the region number scaled to words.
// Assumes the base is word aligned; carries beyond VA_W are dropped.
module walk_l1_index
    import walk_pkg::*;
(
    input  logic [VA_W-1:0] base,
    input  logic [VA_W-1:0] iova,
    output logic [VA_W-1:0] addr
);
    localparam int PAD_W = VA_W - L1_BITS - WORD_SH;

    // scale the region index to a byte offset and add it to the base
    always_comb begin
        addr = base + {{PAD_W{1'b0}}, iova[VA_W-1:SECT_SH], {WORD_SH{1'b0}}};
    end

    logic unused_low;
    assign unused_low = ^iova[SECT_SH-1:0];
endmodule

// File: rtl/walk_decode.sv
// Descriptor decoder for one table level, selected by LEVEL (1 or 2).
// Produces the kind of descriptor, the composed physical address for a leaf,
// and for level 1 the address of the second-level word. Purely combinational.
module walk_decode
    import walk_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [VA_W-1:0] entry,
    input  logic [VA_W-1:0] iova,
    output desc_kind_e      kind,
    output logic [VA_W-1:0] pa,
    output logic [VA_W-1:0] next_addr
);
    generate
        if (LEVEL == 1) begin : g_lvl1
            // region map, table pointer or fault from the two low bits
            always_comb begin
                pa        = '0;
                next_addr = {entry[VA_W-1:PTR_SH], iova[SECT_SH-1:SPG_SH], {WORD_SH{1'b0}}};
                unique case (entry[1:0])
                    2'b10: begin
                        kind = DK_LEAF;
                        pa   = {entry[VA_W-1:SECT_SH], iova[SECT_SH-1:0]};
                    end
                    2'b01:   kind = DK_NEXT;
                    default: kind = DK_FAULT;
                endcase
            end
        end else begin : g_lvl2
            // small page when bit 1 is set, large page on 2'b01, else fault
            always_comb begin
                next_addr = '0;
                pa        = '0;
                if (entry[1]) begin
                    kind = DK_LEAF;
                    pa   = {entry[VA_W-1:SPG_SH], iova[SPG_SH-1:0]};
                end else if (entry[0]) begin
                    kind = DK_LEAF;
                    pa   = {entry[VA_W-1:LPG_SH], iova[LPG_SH-1:0]};
                end else begin
                    kind = DK_FAULT;
                end
            end
        end
    endgenerate

    logic unused_bits;
    assign unused_bits = ^{entry, iova};
endmodule

// File: rtl/iova_walker.sv
// Two-level translation walker: accepts one virtual address at a time,
// reads up to two descriptors over a single-outstanding read port and
// returns a one-cycle result with the physical address or a fault.
// Assumes memory answers every accepted read exactly once.
module iova_walker
    import walk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [VA_W-1:0] tbl_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_iova,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_pa,
    output logic            rsp_fault,
    output logic [VA_W-1:0] rsp_fault_addr
);
    walk_state_e     st, st_nx;
    logic [VA_W-1:0] iova_q, addr_q, pa_q, faddr_q;
    logic            fault_q;
    logic [VA_W-1:0] l1_addr;
    desc_kind_e      k1, k2;
    logic [VA_W-1:0] pa1, pa2, nxt1, nxt2;

    walk_l1_index u_l1_index (
        .base (tbl_base),
        .iova (req_iova),
        .addr (l1_addr)
    );

    walk_decode #(.LEVEL(1)) u_dec1 (
        .entry     (mem_rsp_data),
        .iova      (iova_q),
        .kind      (k1),
        .pa        (pa1),
        .next_addr (nxt1)
    );

    walk_decode #(.LEVEL(2)) u_dec2 (
        .entry     (mem_rsp_data),
        .iova      (iova_q),
        .kind      (k2),
        .pa        (pa2),
        .next_addr (nxt2)
    );

    logic unused_nxt2;
    assign unused_nxt2 = ^nxt2;

    // next-state selection of the walk sequence
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (en && req_valid) st_nx = ST_RD1;
            ST_RD1:  if (mem_req_ready) st_nx = ST_WT1;
            ST_WT1:  if (mem_rsp_valid) st_nx = (k1 == DK_NEXT) ? ST_RD2 : ST_DONE;
            ST_RD2:  if (mem_req_ready) st_nx = ST_WT2;
            ST_WT2:  if (mem_rsp_valid) st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // capture the request, the read address and the walk result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iova_q  <= '0;
            addr_q  <= '0;
            pa_q    <= '0;
            faddr_q <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (en && req_valid) begin
                    iova_q  <= req_iova;
                    addr_q  <= l1_addr;
                    pa_q    <= '0;
                    faddr_q <= '0;
                    fault_q <= 1'b0;
                end
                ST_WT1: if (mem_rsp_valid) begin
                    unique case (k1)
                        DK_LEAF: pa_q <= pa1;
                        DK_NEXT: addr_q <= nxt1;
                        default: begin
                            fault_q <= 1'b1;
                            faddr_q <= iova_q;
                        end
                    endcase
                end
                ST_WT2: if (mem_rsp_valid) begin
                    if (k2 == DK_LEAF) pa_q <= pa2;
                    else begin
                        fault_q <= 1'b1;
                        faddr_q <= iova_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // port outputs decoded from state and result registers
    always_comb begin
        req_ready      = en && (st == ST_IDLE);
        mem_req_valid  = (st == ST_RD1) || (st == ST_RD2);
        mem_req_addr   = addr_q;
        rsp_valid      = (st == ST_DONE);
        rsp_pa         = pa_q;
        rsp_fault      = fault_q;
        rsp_fault_addr = faddr_q;
    end

    // R10: acceptance takes the walker out of the ready state
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: a stalled read request keeps its address
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: no new read while one is outstanding
    p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R11: the result strobe lasts one cycle
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5 / R9: a fault result carries no physical address
    p_fault_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

    // R2: disabled and idle means no memory traffic next cycle
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !req_ready && !mem_req_valid && !rsp_valid && $past(!mem_req_valid)
         && st == ST_IDLE) |=> !mem_req_valid);
endmodule

// File: tb/test_iova_walker.sv
`timescale 1ns/1ps
module test_iova_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_iova = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_fault;
    logic [31:0] rsp_fault_addr;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    iova_walker i_iova_walker (
        .clk(clk), .rst_n(rst_n), .en(en), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_fault_addr(rsp_fault_addr)
    );

    // ---------------- table memory model ----------------
    logic [31:0] tmem [logic [31:0]];
    logic [31:0] rd_log [0:255];
    int          rd_total = 0;
    int          rsp_total = 0;
    logic        pend = 1'b0;
    int          lat = 0;
    logic [31:0] paddr = '0;
    logic        overlap_err = 1'b0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (tmem.exists(a)) return tmem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            pend          <= 1'b0;
            lat           <= 0;
        end else begin
            mem_req_ready <= ~mem_req_ready;
            mem_rsp_valid <= 1'b0;
            if (rsp_valid) rsp_total <= rsp_total + 1;
            if (mem_req_valid && mem_req_ready) begin
                if (pend) overlap_err <= 1'b1;
                pend  <= 1'b1;
                lat   <= 2;
                paddr <= mem_req_addr;
                rd_log[rd_total[7:0]] <= mem_req_addr;
                rd_total <= rd_total + 1;
            end else if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= rd(paddr);
                    pend          <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    // ---------------- check helper ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // ---------------- one translation ----------------
    logic [31:0] o_pa, o_faddr;
    logic        o_fault;
    int          o_reads, o_base_rd;
    logic        busy_err;

    task automatic translate(input logic [31:0] va);
        int cnt;
        busy_err = 1'b0;
        @(negedge clk);
        o_base_rd = rd_total;
        req_iova  = va;
        req_valid = 1'b1;
        cnt = 0;
        while (!req_ready && cnt < 100) begin @(negedge clk); cnt++; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!rsp_valid && cnt < 300) begin
            if (req_ready) busy_err = 1'b1;
            @(negedge clk);
            cnt++;
        end
        o_pa    = rsp_pa;
        o_fault = rsp_fault;
        o_faddr = rsp_fault_addr;
        o_reads = rd_total - o_base_rd;
        @(negedge clk);
        chk("R11 strobe one cycle", {31'b0, rsp_valid}, 32'h0);
    endtask

    // ---------------- vector table ----------------
    localparam int NV = 11;
    localparam logic [31:0] V_IOVA [NV] = '{
        32'h1234_5678, 32'h0020_1ABC, 32'h0030_0000, 32'h0040_7123, 32'h0040_8FFF,
        32'h0041_5ABC, 32'h0041_F000, 32'h0042_0000, 32'hFFFF_FFFF, 32'h000A_BCDE,
        32'h0041_0000 };
    localparam logic [31:0] V_PA [NV] = '{
        32'hABC4_5678, 32'h0, 32'h0, 32'h8765_4123, 32'h1111_1FFF,
        32'h2222_5ABC, 32'h2222_F000, 32'h0, 32'hFFFF_FFFF, 32'h5A5A_BCDE,
        32'h2222_0000 };
    localparam logic V_FLT [NV] = '{0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0};
    localparam int   V_RD  [NV] = '{1, 1, 1, 2, 2, 2, 2, 2, 1, 1, 2};
    localparam string V_REQ [NV] = '{"R4", "R5", "R5", "R7", "R7",
                                     "R8", "R8", "R9", "R4", "R3", "R8"};

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] l1a, l2a;
        // table contents
        tmem[32'h0010_048C] = 32'hABC0_0002;   // region 0x123: section
        tmem[32'h0010_0008] = 32'h0000_0000;   // region 0x002: fault 00
        tmem[32'h0010_000C] = 32'h0000_0003;   // region 0x003: fault 11
        tmem[32'h0010_0010] = 32'h0040_0401;   // region 0x004: pointer
        tmem[32'h0010_3FFC] = 32'hFFF0_0002;   // region 0xFFF: section
        tmem[32'h0010_0000] = 32'h5A50_0002;   // region 0x000: section
        tmem[32'h0040_041C] = 32'h8765_4002;   // slot 0x07: small page
        tmem[32'h0040_0420] = 32'h1111_1003;   // slot 0x08: small page, bit0 set
        for (int k = 0; k < 16; k++) tmem[32'h0040_0440 + 4 * k] = 32'h2222_0001;
        tmem[32'h0040_0480] = 32'h0000_0000;   // slot 0x20: fault
        tmem[32'h0020_048C] = 32'hCDE0_0002;   // alternate base, region 0x123

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        chk("R1 mem_req_valid after reset", {31'b0, mem_req_valid}, 32'h0);
        chk("R1 req_ready with en low", {31'b0, req_ready}, 32'h0);

        // R2: request held while disabled is ignored
        req_iova  = 32'h1234_5678;
        req_valid = 1'b1;
        busy_err  = 1'b0;
        for (int c = 0; c < 12; c++) begin
            if (req_ready || mem_req_valid || rsp_valid) busy_err = 1'b1;
            @(negedge clk);
        end
        chk("R2 no handshake or output while disabled", {31'b0, busy_err}, 32'h0);
        chk("R2 no memory read while disabled", rd_total, 32'h0);
        chk("R2 no response while disabled", rsp_total, 32'h0);
        req_valid = 1'b0;
        en = 1'b1;
        @(negedge clk);
        chk("R1 req_ready once enabled", {31'b0, req_ready}, 32'h1);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            translate(V_IOVA[i]);
            chk({V_REQ[i], " pa"}, o_pa, V_PA[i]);
            chk({V_REQ[i], " fault"}, {31'b0, o_fault}, {31'b0, V_FLT[i]});
            chk({V_REQ[i], " fault addr"}, o_faddr, V_FLT[i] ? V_IOVA[i] : 32'h0);
            chk({V_REQ[i], " read count"}, o_reads, V_RD[i]);
            l1a = tbl_base + {18'b0, V_IOVA[i][31:20], 2'b00};
            chk("R3 first read address", rd_log[o_base_rd[7:0]], l1a);
            if (V_RD[i] == 2) begin
                l2a = {rd(l1a)[31:10], V_IOVA[i][19:12], 2'b00};
                chk("R6 second read address", rd_log[(o_base_rd + 1) % 256], l2a);
            end
            chk("R10 req_ready low while busy", {31'b0, busy_err}, 32'h0);
        end

        // R3: a different table base
        tbl_base = 32'h0020_0000;
        translate(32'h1234_5678);
        chk("R3 alternate base pa", o_pa, 32'hCDE4_5678);
        chk("R3 alternate base read", rd_log[o_base_rd[7:0]], 32'h0020_048C);
        tbl_base = 32'h0010_0000;

        // R1: reset in the middle of a walk
        @(negedge clk);
        req_iova  = 32'h0040_7123;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-walk reset mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
        chk("R1 mid-walk reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after mid-walk reset", {31'b0, req_ready}, 32'h1);
        translate(32'h0040_7123);
        chk("R7 walk after reset", o_pa, 32'h8765_4123);

        chk("R10 never two reads outstanding", {31'b0, overlap_err}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule